// File: doc/BRIEF.md
# Aligned write burst splitter

The block turns one write request, expressed as a start address on a 32-byte grid and a count of 32-byte atoms, into a series of write bursts on a memory bus whose data path is 64 bytes wide. The atoms arrive on their own valid/ready queue. Two atoms at a time are packed into a single 64-byte beat, with the atom at the lower address in the lower half. When the request starts or ends halfway through a 64-byte word, the missing half is filled with zero data and its byte enables are cleared. No atom is consumed for that half.

Bursts never cross a boundary that is a multiple of the maximum transaction size. Every beat carries the header of the burst it belongs to: the address, the beat count, a fixed client ID, a size code, and an acknowledge-tracking flag. That flag is raised only on the burst that finishes a request whose command asked for an acknowledge. A new command is accepted only after the last beat of the previous request has left the block.

Top module: `wbs_splitter`

## Requirements
- R1: Out of reset `cmd_ready` is 1 and `out_valid` is 0. `cmd_ready` stays 0 from the cycle after a command is accepted until the final beat of that request has been transferred.
- R2: A request with start address A and N atoms (N at least 1) produces exactly (N + A[5] + (A[5] xor N[0])) / 2 beats. Their bases are consecutive 64-byte words, starting at A with bits 5:0 cleared.
- R3: A burst ends after the beat that completes the request, or after the beat whose successor base is a multiple of MAX_XFER. `out_len` gives the number of beats in the burst. `out_first` marks the first beat of the burst and `out_last` marks its final beat.
- R4: When A[5] is 1, the first beat of the request has `out_strb[31:0]` equal to 0 and `out_data[255:0]` equal to 0.
- R5: When the request end (A + 32*N) has bit 5 set, the final beat has `out_strb[63:32]` equal to 0 and `out_data[511:256]` equal to 0. All other strobe halves are all ones.
- R6: Atoms are consumed in arrival order and placed at increasing addresses, with the lower half of a beat filled before the upper half. A padded half consumes no atom.
- R7: `out_addr` is the base of the burst's first beat. For the first burst of a request with A[5] equal to 1, it is that base plus 32 instead.
- R8: `out_id` always equals CLIENT_ID, and `out_size` is 6, the base-2 logarithm of the 64-byte beat.
- R9: `out_ack` is 1 on every beat of the burst that completes a request whose `cmd_ack` was 1, and 0 on every beat of all other bursts.
- R10: While `out_valid` is 1 and `out_ready` is 0, the header outputs (`out_addr`, `out_len`, `out_ack`) hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write request offered |
| cmd_ready | output | 1 | Block is idle and takes the request |
| cmd_addr | input | ADDR_W | Start address, bits 4:0 ignored |
| cmd_atoms | input | LEN_W | Number of 32-byte atoms, at least 1 |
| cmd_ack | input | 1 | Request wants an acknowledge |
| atom_valid | input | 1 | Atom offered |
| atom_ready | output | 1 | Atom taken |
| atom_data | input | 256 | 32-byte atom |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Bus accepts beat |
| out_addr | output | ADDR_W | Burst start address |
| out_len | output | BL_W | Beats in the burst |
| out_size | output | 3 | Beat size code (6) |
| out_id | output | ID_W | Client transaction ID |
| out_data | output | 512 | Beat data |
| out_strb | output | 64 | Byte enables |
| out_first | output | 1 | First beat of burst |
| out_last | output | 1 | Final beat of burst |
| out_ack | output | 1 | Acknowledge-tracking flag |

## Verification
The bench builds the block with MAX_XFER set to 128 instead of the default 256. Boundaries then fall every second beat, so most requests split into several bursts, and single-beat bursts at odd starting words are common. LEN_W is set to 6, which keeps requests short enough that head padding, tail padding, both paddings, and one-beat requests all occur many times in a short random run. A mid-burst stall on the output then lands on every kind of header.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int ATOM_BYTES = 32;
  localparam int BEAT_BYTES = 2 * ATOM_BYTES;
  localparam int ATOM_SH    = $clog2(ATOM_BYTES);
  localparam int BEAT_SH    = $clog2(BEAT_BYTES);
  localparam int ATOM_W     = ATOM_BYTES * 8;
  localparam int BEAT_W     = BEAT_BYTES * 8;

  typedef enum logic {ST_IDLE, ST_RUN} wbs_state_e;
endpackage

// File: rtl/wbs_cmd_decode.sv
module wbs_cmd_decode
  import wbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  localparam int BT_W  = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  atoms,
  output logic              head_pad,
  output logic              tail_pad,
  output logic [ADDR_W-1:0] pad_base,
  output logic [BT_W-1:0]   beats
);
  logic [BT_W-1:0] padded;

  always_comb begin
    head_pad = addr[ATOM_SH];
    // addr[4:0] is zero, so bit 5 of the end address is a parity of two bits
    tail_pad = addr[ATOM_SH] ^ atoms[0];
    pad_base = {addr[ADDR_W-1:BEAT_SH], {BEAT_SH{1'b0}}};
    padded   = BT_W'(atoms) + BT_W'(head_pad) + BT_W'(tail_pad);
    beats    = padded >> 1;
  end
endmodule

// File: rtl/wbs_burst_len.sv
module wbs_burst_len
  import wbs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BT_W     = 9,
  parameter int MAX_XFER = 256,
  localparam int MAX_BEATS = MAX_XFER / BEAT_BYTES,
  localparam int BL_W      = $clog2(MAX_BEATS) + 1,
  localparam int XS_W      = $clog2(MAX_XFER)
) (
  input  logic [ADDR_W-1:0] cur_base,
  input  logic [BT_W-1:0]   beats_left,
  output logic [BL_W-1:0]   len
);
  logic [BL_W-1:0] to_bnd;

  always_comb begin
    to_bnd = BL_W'(MAX_BEATS) - BL_W'(cur_base[XS_W-1:BEAT_SH]);
    if (beats_left < BT_W'(to_bnd)) len = BL_W'(beats_left);
    else                            len = to_bnd;
  end
endmodule

// File: rtl/wbs_beat_pack.sv
module wbs_beat_pack
  import wbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              need_lo,
  input  logic              need_hi,
  input  logic              atom_valid,
  input  logic [ATOM_W-1:0] atom_data,
  output logic              atom_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BEAT_W-1:0] out_data,
  output logic [BEAT_BYTES-1:0] out_strb,
  output logic              fire
);
  logic              lo_have_q, lo_have_d;
  logic [ATOM_W-1:0] lo_q;
  logic              lo_ok, lo_cap;

  always_comb begin
    lo_ok      = !need_lo || lo_have_q;
    lo_cap     = active && need_lo && !lo_have_q && atom_valid;
    out_valid  = active && lo_ok && (!need_hi || atom_valid);
    atom_ready = active && ((need_lo && !lo_have_q) || (lo_ok && need_hi && out_ready));
    fire       = out_valid && out_ready;
    out_data   = {(need_hi ? atom_data : {ATOM_W{1'b0}}),
                  (need_lo ? lo_q      : {ATOM_W{1'b0}})};
    out_strb   = {{ATOM_BYTES{need_hi}}, {ATOM_BYTES{need_lo}}};
    lo_have_d  = lo_have_q;
    if (fire)        lo_have_d = 1'b0;
    else if (lo_cap) lo_have_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_have_q <= 1'b0;
    else        lo_have_q <= lo_have_d;
  end

  always_ff @(posedge clk) begin
    if (lo_cap) lo_q <= atom_data;
  end

  p_lo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_have_q && !fire) |=> (lo_have_q && $stable(lo_q)));
endmodule

// File: rtl/wbs_splitter.sv
module wbs_splitter
  import wbs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int MAX_XFER  = 256,
  parameter int ID_W      = 4,
  parameter logic [ID_W-1:0] CLIENT_ID = 4'h5,
  localparam int BT_W      = LEN_W + 1,
  localparam int MAX_BEATS = MAX_XFER / BEAT_BYTES,
  localparam int BL_W      = $clog2(MAX_BEATS) + 1,
  localparam int XS_W      = $clog2(MAX_XFER)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [LEN_W-1:0]      cmd_atoms,
  input  logic                  cmd_ack,
  input  logic                  atom_valid,
  output logic                  atom_ready,
  input  logic [ATOM_W-1:0]     atom_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [BL_W-1:0]       out_len,
  output logic [2:0]            out_size,
  output logic [ID_W-1:0]       out_id,
  output logic [BEAT_W-1:0]     out_data,
  output logic [BEAT_BYTES-1:0] out_strb,
  output logic                  out_first,
  output logic                  out_last,
  output logic                  out_ack
);
  wbs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d, haddr_q, haddr_d;
  logic [BT_W-1:0]   left_q, left_d;
  logic [BL_W-1:0]   rem_q, rem_d, hlen_q, hlen_d;
  logic              head_q, head_d, tail_q, tail_d, ack_q, ack_d;
  logic              first_q, first_d, inb_q, inb_d, hfin_q, hfin_d;

  logic              dec_head, dec_tail;
  logic [ADDR_W-1:0] dec_base;
  logic [BT_W-1:0]   dec_beats;
  logic [BL_W-1:0]   calc_len, eff_len, eff_rem;
  logic [ADDR_W-1:0] eff_addr;
  logic              eff_fin, active, need_lo, need_hi, fire, ld_cmd;

  wbs_cmd_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .addr(cmd_addr), .atoms(cmd_atoms), .head_pad(dec_head),
    .tail_pad(dec_tail), .pad_base(dec_base), .beats(dec_beats));

  wbs_burst_len #(.ADDR_W(ADDR_W), .BT_W(BT_W), .MAX_XFER(MAX_XFER)) u_len (
    .cur_base(base_q), .beats_left(left_q), .len(calc_len));

  wbs_beat_pack u_pack (
    .clk(clk), .rst_n(rst_n), .active(active), .need_lo(need_lo),
    .need_hi(need_hi), .atom_valid(atom_valid), .atom_data(atom_data),
    .atom_ready(atom_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_strb(out_strb), .fire(fire));

  always_comb begin
    active    = (state_q == ST_RUN);
    cmd_ready = (state_q == ST_IDLE);
    ld_cmd    = cmd_ready && cmd_valid;
    need_lo   = !(first_q && head_q);
    need_hi   = !((left_q == BT_W'(1)) && tail_q);
    eff_len   = inb_q ? hlen_q : calc_len;
    eff_rem   = inb_q ? rem_q  : calc_len;
    eff_fin   = inb_q ? hfin_q : (BT_W'(calc_len) == left_q);
    eff_addr  = inb_q ? haddr_q
                      : base_q + ((first_q && head_q) ? ADDR_W'(ATOM_BYTES) : '0);
    out_addr  = eff_addr;
    out_len   = eff_len;
    out_first = !inb_q;
    out_last  = (eff_rem == BL_W'(1));
    out_ack   = ack_q && eff_fin;
    out_size  = 3'(BEAT_SH);
    out_id    = CLIENT_ID;
  end

  always_comb begin
    state_d = state_q; base_d = base_q; left_d = left_q;
    head_d = head_q; tail_d = tail_q; ack_d = ack_q; first_d = first_q;
    inb_d = inb_q; rem_d = rem_q; haddr_d = haddr_q; hlen_d = hlen_q; hfin_d = hfin_q;
    if (ld_cmd) begin
      state_d = ST_RUN;  base_d = dec_base; left_d = dec_beats;
      head_d  = dec_head; tail_d = dec_tail; ack_d = cmd_ack;
      first_d = 1'b1;     inb_d  = 1'b0;
    end else if (fire) begin
      base_d  = base_q + ADDR_W'(BEAT_BYTES);
      left_d  = left_q - BT_W'(1);
      first_d = 1'b0;
      if (eff_rem == BL_W'(1)) begin
        inb_d = 1'b0;
      end else begin
        inb_d   = 1'b1;
        rem_d   = eff_rem - BL_W'(1);
        haddr_d = eff_addr; hlen_d = eff_len; hfin_d = eff_fin;
      end
      if (left_q == BT_W'(1)) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; inb_q <= 1'b0; first_q <= 1'b0; left_q <= '0;
      head_q <= 1'b0; tail_q <= 1'b0; ack_q <= 1'b0; base_q <= '0;
      rem_q <= '0; haddr_q <= '0; hlen_q <= '0; hfin_q <= 1'b0;
    end else begin
      state_q <= state_d; inb_q <= inb_d; first_q <= first_d; left_q <= left_d;
      head_q <= head_d; tail_q <= tail_d; ack_q <= ack_d; base_q <= base_d;
      rem_q <= rem_d; haddr_q <= haddr_d; hlen_q <= hlen_d; hfin_q <= hfin_d;
    end
  end

  p_busy_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |->
      ((BL_W+1)'(out_addr[XS_W-1:BEAT_SH]) + (BL_W+1)'(out_len) <= (BL_W+1)'(MAX_BEATS)));

  p_ack_ends_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && out_ack) |=> cmd_ready);

  p_hdr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      ($stable(out_addr) && $stable(out_len) && $stable(out_ack)));
endmodule

// File: tb/wbs_splitter_test.sv
module wbs_splitter_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W = 6;
  localparam int MAX_XFER = 128;
  localparam int ID_W = 4;
  localparam logic [ID_W-1:0] CID = 4'h9;
  localparam int BL_W = $clog2(MAX_XFER / 64) + 1;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_ack;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0] cmd_atoms;
  logic atom_valid, atom_ready;
  logic [255:0] atom_data;
  logic out_valid, out_ready, out_first, out_last, out_ack;
  logic [ADDR_W-1:0] out_addr;
  logic [BL_W-1:0] out_len;
  logic [2:0] out_size;
  logic [ID_W-1:0] out_id;
  logic [511:0] out_data;
  logic [63:0] out_strb;

  wbs_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_XFER(MAX_XFER),
                 .ID_W(ID_W), .CLIENT_ID(CID)) uut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;

  logic [ADDR_W-1:0] cq_addr[$];
  int cq_n[$];
  bit cq_ack[$];
  logic [255:0] aq[$];
  logic [511:0] e_data[$];
  logic [63:0] e_strb[$];
  logic [ADDR_W-1:0] e_addr[$];
  int e_len[$], e_kind[$];
  bit e_first[$], e_last[$], e_ack[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd_atom();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic add_cmd(input int addr, input int n, input bit ack);
    logic [255:0] loc[$];
    int h, t, pb, beats, a, i, j;
    cq_addr.push_back(ADDR_W'(addr)); cq_n.push_back(n); cq_ack.push_back(ack);
    for (int k = 0; k < n; k++) begin
      logic [255:0] v;
      v = rnd_atom();
      loc.push_back(v); aq.push_back(v);
    end
    h = (addr >> 5) & 1;
    t = h ^ (n & 1);
    pb = addr & ~63;
    beats = (n + h + t) / 2;
    a = 0; i = 0;
    while (i < beats) begin
      j = i + 1;
      while (j < beats && ((pb + 64 * j) % MAX_XFER) != 0) j++;
      for (int k = i; k < j; k++) begin
        logic [255:0] lo, hi;
        logic [63:0] st;
        int kind;
        kind = 0; st = '1;
        if (k == 0 && h == 1) begin lo = '0; st[31:0] = '0; kind = 1; end
        else begin lo = loc[a]; a++; end
        if (k == beats - 1 && t == 1) begin hi = '0; st[63:32] = '0; kind = kind + 2; end
        else begin hi = loc[a]; a++; end
        e_data.push_back({hi, lo}); e_strb.push_back(st); e_kind.push_back(kind);
        e_addr.push_back(ADDR_W'(pb + 64 * i + ((i == 0 && h == 1) ? 32 : 0)));
        e_len.push_back(j - i); e_first.push_back(k == i); e_last.push_back(k == j - 1);
        e_ack.push_back(ack && (j == beats));
      end
      i = j;
    end
  endtask

  initial begin
    int pending, cyc, fired, total;
    bit stall;
    logic [ADDR_W-1:0] s_addr;
    logic [BL_W-1:0] s_len;
    logic s_ack;
    void'($urandom(32'd2718));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_atoms = '0; cmd_ack = 1'b0;
    atom_valid = 1'b0; atom_data = '0; out_ready = 1'b0;
    // directed corners
    add_cmd(32'h1000, 2, 1'b1);  // aligned single beat
    add_cmd(32'h1020, 1, 1'b1);  // head pad only
    add_cmd(32'h1040, 1, 1'b0);  // tail pad only
    add_cmd(32'h1060, 2, 1'b1);  // both pads, two beats
    add_cmd(32'h10E0, 20, 1'b1); // crosses several boundaries
    add_cmd(32'h2040, 9, 1'b0);  // starts at odd word, tail pad
    for (int r = 0; r < 60; r++)
      add_cmd(($urandom % 4096) * 32, 1 + ($urandom % 40), 1'($urandom % 2));
    total = e_data.size();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R1", "cmd_ready in reset", 512'(cmd_ready), 512'(1));
    chk(out_valid === 1'b0, "R1", "out_valid in reset", 512'(out_valid), 512'(0));
    rst_n = 1'b1;
    pending = 0; cyc = 0; fired = 0; stall = 1'b0;
    s_addr = '0; s_len = '0; s_ack = 1'b0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "R2", "watchdog expired", 512'(cyc), 512'(0));
        break;
      end
      if (cq_n.size() == 0 && pending == 0 && e_data.size() == 0) break;
      cmd_valid = (cq_n.size() > 0) && ($urandom % 3 != 0);
      cmd_addr  = (cq_n.size() > 0) ? cq_addr[0] : '0;
      cmd_atoms = (cq_n.size() > 0) ? LEN_W'(cq_n[0]) : '0;
      cmd_ack   = (cq_n.size() > 0) ? cq_ack[0] : 1'b0;
      atom_valid = (aq.size() > 0) && ((cyc < 400) || ($urandom % 4 != 0));
      atom_data  = (aq.size() > 0) ? aq[0] : '0;
      out_ready  = (cyc > 2000) ? 1'b1 : ($urandom % 4 != 0);
      #1;
      if (pending > 0)
        chk(cmd_ready === 1'b0, "R1", "cmd_ready while busy", 512'(cmd_ready), 512'(0));
      if (stall && out_valid) begin
        chk(out_addr === s_addr && out_len === s_len && out_ack === s_ack, "R10",
            "header moved during stall", 512'({out_addr, out_len, out_ack}),
            512'({s_addr, s_len, s_ack}));
      end
      stall = out_valid && !out_ready;
      s_addr = out_addr; s_len = out_len; s_ack = out_ack;
      if (out_valid && out_ready) begin
        if (e_data.size() == 0) begin
          chk(1'b0, "R2", "extra beat", 512'(out_addr), 512'(0));
        end else begin
          string sreq;
          sreq = (e_kind[0] == 1) ? "R4" : (e_kind[0] == 2) ? "R5" : "R2";
          chk(out_strb === e_strb[0], sreq, "strobe", 512'(out_strb), 512'(e_strb[0]));
          chk(out_data === e_data[0], "R6", "data", out_data, e_data[0]);
          chk(out_addr === e_addr[0], "R7", "burst address", 512'(out_addr), 512'(e_addr[0]));
          chk(int'(out_len) == e_len[0] && out_first === e_first[0] && out_last === e_last[0],
              "R3", "len/first/last", 512'({out_len, out_first, out_last}),
              512'({BL_W'(e_len[0]), e_first[0], e_last[0]}));
          chk(out_id === CID && out_size === 3'd6, "R8", "id/size",
              512'({out_id, out_size}), 512'({CID, 3'd6}));
          chk(out_ack === e_ack[0], "R9", "ack flag", 512'(out_ack), 512'(e_ack[0]));
          void'(e_data.pop_front()); void'(e_strb.pop_front()); void'(e_addr.pop_front());
          void'(e_len.pop_front()); void'(e_kind.pop_front()); void'(e_first.pop_front());
          void'(e_last.pop_front()); void'(e_ack.pop_front());
          pending--; fired++;
        end
      end
      if (atom_valid && atom_ready) void'(aq.pop_front());
      if (cmd_valid && cmd_ready) begin
        int h, n;
        n = cq_n[0];
        h = int'(cq_addr[0][5]);
        pending += (n + h + (h ^ (n & 1))) / 2;
        void'(cq_addr.pop_front()); void'(cq_n.pop_front()); void'(cq_ack.pop_front());
      end
    end
    chk(fired == total, "R2", "total beats", 512'(fired), 512'(total));
    chk(aq.size() == 0, "R6", "atoms left over", 512'(aq.size()), 512'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule